// File: doc/BRIEF.md
# Floating-Point Status and Exception Controller

This block sits next to the floating-point execution unit of a simple in-order core. When an operation completes, the unit presents a strobe together with several values: the result, the destination register index, the address of the instruction and five raw IEEE-754 exception flags. The controller folds those flags into a sticky status register, which software can read and write. It then decides whether the result reaches the register file and whether an exception request goes to the trap logic. It also supplies the return address that the trap logic saves.

Each completing operation brings its own flag set, which is consumed in that cycle. An exception is requested only when that operation raises at least one flag while the global enable bit is set. The request appears in the cycle after the strobe and holds until the trap logic acknowledges it. Compare operations pass their flags through the same path, but they never write a register.

A parameter selects the commit policy. By default the result is written and the trap follows, with the return address pointing past the faulting instruction. The precise alternative drops the write and returns to the faulting instruction itself.

Top module: `fpexc_unit`

## Requirements
- R1: The status register is read on `csrRdData`. Bit 0 is the exception enable. Raw flag input bits (bit 0 inexact, bit 1 divide-by-zero, bit 2 underflow, bit 3 overflow, bit 4 invalid) are recorded in status bits 3, 5, 2, 1 and 4 respectively.
- R2: Status flag bits are sticky. An accepted operation ORs its flags into them. Only a software write through `csrWrEn`/`csrWrData` can clear them.
- R3: Flags belong only to the operation that presents them. An operation with no flags raises no request, even directly after one that had flags.
- R4: `excReq` rises in the cycle after an accepted strobe only if that operation has at least one flag set and the effective enable bit is 1. It then stays high until `excAck`, and falls in the cycle after `excAck`.
- R5: With `COMMIT_FIRST`=1, `wbEn` is asserted in the strobe cycle of a non-compare operation even when it traps. `excPc` becomes the instruction address plus `INSN_BYTES`.
- R6: With `COMMIT_FIRST`=0, a trapping operation does not assert `wbEn`, and `excPc` becomes the address of the faulting instruction.
- R7: A compare operation (`cmplIsCmp`=1) updates the status flags and can trap, but it never asserts `wbEn`.
- R8: A software write in the same cycle as an accepted operation supplies the enable bit used for that operation's trap decision. The stored value is the written value ORed with the new flags.
- R9: While `excReq` is high, completion strobes are ignored: they cause no write-back and no status change.
- R10: After reset the status register reads 0, and `excReq` and `wbEn` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmplValid | input | 1 | Operation completion strobe |
| cmplIsCmp | input | 1 | Completing operation is a compare (no register result) |
| cmplFlags | input | 5 | Raw exception flags of the completing operation |
| cmplResult | input | DATA_W | Result value |
| cmplDest | input | IDX_W | Destination register index |
| cmplPc | input | ADDR_W | Address of the completing instruction |
| csrWrEn | input | 1 | Software write strobe for the status register |
| csrWrData | input | 6 | Software write value |
| csrRdData | output | 6 | Current status register value |
| wbEn | output | 1 | Register file write enable |
| wbDest | output | IDX_W | Register file write index |
| wbData | output | DATA_W | Register file write data |
| excReq | output | 1 | Floating-point exception request to trap logic |
| excAck | input | 1 | Trap logic acknowledge |
| excPc | output | ADDR_W | Exception return address |

## Verification
The hardest case to reach from the ports is the one where a software write and a trapping completion land in the same cycle. Here the written enable has to decide the trap, and the new flags have to land on top of the written value. The bench reaches this case by driving both strobes at the same falling edge. It does so while the stored enable is 0, so only the written enable can cause the trap. The bench also sweeps every flag pattern, with the enable both clear and set, for both operation kinds. Two instances, one for each commit policy, receive the same stimulus. While a request is still pending, the bench presents an all-flags strobe to show that it is ignored.

// File: rtl/fpexc_pkg.sv
package fpexc_pkg;
  localparam int RAW_INX = 0;
  localparam int RAW_DZ  = 1;
  localparam int RAW_UNF = 2;
  localparam int RAW_OVF = 3;
  localparam int RAW_INV = 4;
  localparam int RAW_W   = 5;

  localparam int ST_EN  = 0;
  localparam int ST_OVF = 1;
  localparam int ST_UNF = 2;
  localparam int ST_INX = 3;
  localparam int ST_INV = 4;
  localparam int ST_DZ  = 5;
  localparam int ST_W   = 6;

  typedef struct packed {
    logic accept;
    logic wbFire;
    logic trapSet;
    logic trapClr;
  } ctlStrobe_t;

  function automatic int rawToStat(input int rawIdx);
    case (rawIdx)
      RAW_INX: return ST_INX;
      RAW_DZ:  return ST_DZ;
      RAW_UNF: return ST_UNF;
      RAW_OVF: return ST_OVF;
      default: return ST_INV;
    endcase
  endfunction
endpackage

// File: rtl/fpexc_ctl.sv
module fpexc_ctl
  import fpexc_pkg::*;
#(
  parameter bit COMMIT_FIRST = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmplValid,
  input  logic       trapCond,
  input  logic       excAck,
  output ctlStrobe_t strb,
  output logic       excReq
);
  logic excReqQ;

  always_comb begin
    strb.accept  = cmplValid & ~excReqQ;
    strb.trapSet = strb.accept & trapCond;
    strb.wbFire  = strb.accept & (COMMIT_FIRST ? 1'b1 : ~trapCond);
    strb.trapClr = excReqQ & excAck;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              excReqQ <= 1'b0;
    else if (strb.trapSet)  excReqQ <= 1'b1;
    else if (strb.trapClr)  excReqQ <= 1'b0;
  end

  assign excReq = excReqQ;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (excReq && !excAck) |=> excReq) else $error("AST_REQ_HOLD");  // R4
  AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(excReq) |-> $past(cmplValid)) else $error("AST_REQ_CAUSE");  // R4
  AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (excReq && excAck) |=> !excReq) else $error("AST_ACK_DROP");  // R4
endmodule

// File: rtl/fpexc_dpath.sv
module fpexc_dpath
  import fpexc_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int IDX_W        = 5,
  parameter int ADDR_W       = 32,
  parameter int INSN_BYTES   = 4,
  parameter bit COMMIT_FIRST = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic              cmplIsCmp,
  input  logic [RAW_W-1:0]  cmplFlags,
  input  logic [DATA_W-1:0] cmplResult,
  input  logic [IDX_W-1:0]  cmplDest,
  input  logic [ADDR_W-1:0] cmplPc,
  input  logic              csrWrEn,
  input  logic [ST_W-1:0]   csrWrData,
  output logic              trapCond,
  output logic [ST_W-1:0]   csrRdData,
  output logic              wbEn,
  output logic [IDX_W-1:0]  wbDest,
  output logic [DATA_W-1:0] wbData,
  output logic [ADDR_W-1:0] excPc
);
  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(INSN_BYTES);

  logic [ST_W-1:0]   statQ;
  logic [ST_W-1:0]   newBits;
  logic [ST_W-1:0]   baseStat;
  logic [ADDR_W-1:0] excPcQ;
  logic [ADDR_W-1:0] savePc;

  always_comb begin
    newBits = '0;
    for (int i = 0; i < RAW_W; i++) begin
      newBits[rawToStat(i)] = cmplFlags[i];
    end
  end

  assign baseStat = csrWrEn ? csrWrData : statQ;
  assign trapCond = (|cmplFlags) & baseStat[ST_EN];

  always_ff @(posedge clk) begin
    if (!rstN)            statQ <= '0;
    else if (strb.accept) statQ <= baseStat | newBits;
    else                  statQ <= baseStat;
  end

  generate
    if (COMMIT_FIRST) begin : g_nextPc
      assign savePc = cmplPc + PC_STEP;
    end else begin : g_thisPc
      assign savePc = cmplPc;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)             excPcQ <= '0;
    else if (strb.trapSet) excPcQ <= savePc;
  end

  assign csrRdData = statQ;
  assign excPc     = excPcQ;
  assign wbEn      = strb.wbFire & ~cmplIsCmp;
  assign wbDest    = cmplDest;
  assign wbData    = cmplResult;

  AST_STICKY_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    !csrWrEn |=> ((statQ[ST_W-1:1] & $past(statQ[ST_W-1:1])) == $past(statQ[ST_W-1:1])))
    else $error("AST_STICKY_FLAGS");  // R2
  AST_ENABLE_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    !csrWrEn |=> (statQ[ST_EN] == $past(statQ[ST_EN]))) else $error("AST_ENABLE_KEEP");  // R2
  AST_PRECISE_NO_WB: assert property (@(posedge clk) disable iff (!rstN)
    (!COMMIT_FIRST && strb.trapSet) |-> !wbEn) else $error("AST_PRECISE_NO_WB");  // R6
endmodule

// File: rtl/fpexc_unit.sv
module fpexc_unit
  import fpexc_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int IDX_W        = 5,
  parameter int ADDR_W       = 32,
  parameter int INSN_BYTES   = 4,
  parameter bit COMMIT_FIRST = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmplValid,
  input  logic              cmplIsCmp,
  input  logic [4:0]        cmplFlags,
  input  logic [DATA_W-1:0] cmplResult,
  input  logic [IDX_W-1:0]  cmplDest,
  input  logic [ADDR_W-1:0] cmplPc,
  input  logic              csrWrEn,
  input  logic [5:0]        csrWrData,
  output logic [5:0]        csrRdData,
  output logic              wbEn,
  output logic [IDX_W-1:0]  wbDest,
  output logic [DATA_W-1:0] wbData,
  output logic              excReq,
  input  logic              excAck,
  output logic [ADDR_W-1:0] excPc
);
  ctlStrobe_t strb;
  logic       trapCond;

  fpexc_ctl #(.COMMIT_FIRST(COMMIT_FIRST)) u_ctl (
    .clk(clk), .rstN(rstN), .cmplValid(cmplValid), .trapCond(trapCond),
    .excAck(excAck), .strb(strb), .excReq(excReq)
  );

  fpexc_dpath #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W),
    .INSN_BYTES(INSN_BYTES), .COMMIT_FIRST(COMMIT_FIRST)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .cmplIsCmp(cmplIsCmp),
    .cmplFlags(cmplFlags), .cmplResult(cmplResult), .cmplDest(cmplDest),
    .cmplPc(cmplPc), .csrWrEn(csrWrEn), .csrWrData(csrWrData),
    .trapCond(trapCond), .csrRdData(csrRdData), .wbEn(wbEn),
    .wbDest(wbDest), .wbData(wbData), .excPc(excPc)
  );

  AST_PENDING_NO_WB: assert property (@(posedge clk) disable iff (!rstN)
    excReq |-> !wbEn) else $error("AST_PENDING_NO_WB");  // R9
  AST_PENDING_STAT: assert property (@(posedge clk) disable iff (!rstN)
    (excReq && !csrWrEn) |=> $stable(csrRdData)) else $error("AST_PENDING_STAT");  // R9
  AST_CMP_NO_WB: assert property (@(posedge clk) disable iff (!rstN)
    cmplIsCmp |-> !wbEn) else $error("AST_CMP_NO_WB");  // R7
endmodule

// File: tb/fpexc_unit_tb.sv
module fpexc_unit_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmplValid = 1'b0, cmplIsCmp = 1'b0, csrWrEn = 1'b0, excAck = 1'b0;
  logic [4:0]  cmplFlags = '0;
  logic [31:0] cmplResult = '0, cmplPc = '0;
  logic [4:0]  cmplDest = '0;
  logic [5:0]  csrWrData = '0;

  logic [5:0]  rdA, rdB;
  logic        wbA, wbB, reqA, reqB;
  logic [4:0]  dstA, dstB;
  logic [31:0] datA, datB, pcA, pcB;

  int checks = 0;
  int failures = 0;
  logic [5:0] model = '0;

  always #10 clk = ~clk;

  fpexc_unit #(.COMMIT_FIRST(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .cmplValid(cmplValid), .cmplIsCmp(cmplIsCmp),
    .cmplFlags(cmplFlags), .cmplResult(cmplResult), .cmplDest(cmplDest),
    .cmplPc(cmplPc), .csrWrEn(csrWrEn), .csrWrData(csrWrData),
    .csrRdData(rdA), .wbEn(wbA), .wbDest(dstA), .wbData(datA),
    .excReq(reqA), .excAck(excAck), .excPc(pcA)
  );

  fpexc_unit #(.COMMIT_FIRST(1'b0)) u_dutP (
    .clk(clk), .rstN(rstN), .cmplValid(cmplValid), .cmplIsCmp(cmplIsCmp),
    .cmplFlags(cmplFlags), .cmplResult(cmplResult), .cmplDest(cmplDest),
    .cmplPc(cmplPc), .csrWrEn(csrWrEn), .csrWrData(csrWrData),
    .csrRdData(rdB), .wbEn(wbB), .wbDest(dstB), .wbData(datB),
    .excReq(reqB), .excAck(excAck), .excPc(pcB)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] mapFlags(input logic [4:0] f);
    logic [5:0] m;
    m = '0;
    m[3] = f[0]; m[5] = f[1]; m[2] = f[2]; m[1] = f[3]; m[4] = f[4];
    return m;
  endfunction

  task automatic csrWrite(input logic [5:0] v);
    @(negedge clk);
    csrWrEn = 1'b1; csrWrData = v;
    @(negedge clk);
    csrWrEn = 1'b0;
    model = v;
    #1;
    check("R2 sw write", {rdA, rdB}, {v, v});
  endtask

  task automatic ack();
    @(negedge clk);
    excAck = 1'b1;
    @(negedge clk);
    excAck = 1'b0;
    #1;
    check("R4 ack drops req", {reqA, reqB}, 2'b00);
  endtask

  task automatic doOp(input logic [4:0] f, input logic isCmp, input logic [31:0] pc);
    logic expTrap;
    @(negedge clk);
    cmplValid = 1'b1; cmplIsCmp = isCmp; cmplFlags = f; cmplPc = pc;
    cmplResult = pc ^ 32'h5a5a_0f0f; cmplDest = pc[6:2];
    expTrap = model[0] && (f != 5'd0);
    #5;
    if (isCmp) check("R7 cmp no wb", {wbA, wbB}, 2'b00);
    else begin
      check("R5 commit wb", wbA, 1'b1);
      check("R6 precise wb", wbB, !expTrap);
      check("R5 wb data", {datA, dstA}, {pc ^ 32'h5a5a_0f0f, pc[6:2]});
    end
    @(negedge clk);
    cmplValid = 1'b0;
    model = model | mapFlags(f);
    #1;
    check("R1 status map", {rdA, rdB}, {model, model});
    if (f == 5'd0) check("R3 no flags no req", {reqA, reqB}, 2'b00);
    else check("R4 req decision", {reqA, reqB}, {expTrap, expTrap});
    if (expTrap) begin
      check("R5 next pc", pcA, pc + 32'd4);
      check("R6 fault pc", pcB, pc);
      ack();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R10 reset", {rdA, rdB, reqA, reqB, wbA, wbB}, '0);

    for (int en = 0; en < 2; en++) begin
      for (int f = 0; f < 32; f++) begin
        for (int c = 0; c < 2; c++) begin
          csrWrite({5'd0, en[0]});
          doOp(f[4:0], c[0], 32'h1000 + 32'(f * 8 + c * 4));
        end
      end
    end

    // R2: accumulate without clearing, enable off
    csrWrite(6'd0);
    doOp(5'b00001, 1'b0, 32'h2000);
    doOp(5'b01000, 1'b0, 32'h2004);
    check("R2 sticky accumulate", rdA, 6'b001010);

    // R3: flagged op then clean op with enable on
    csrWrite(6'd1);
    doOp(5'b00010, 1'b0, 32'h3000);
    doOp(5'b00000, 1'b0, 32'h3004);

    // R8: write and op in same cycle, stored enable 0
    csrWrite(6'b001000);
    @(negedge clk);
    csrWrEn = 1'b1; csrWrData = 6'b000001;
    cmplValid = 1'b1; cmplIsCmp = 1'b0; cmplFlags = 5'b01000; cmplPc = 32'h4000;
    #5;
    check("R8 precise uses written enable", {wbA, wbB}, 2'b10);
    @(negedge clk);
    csrWrEn = 1'b0; cmplValid = 1'b0;
    #1;
    check("R8 written or flags", {rdA, rdB}, {6'b000011, 6'b000011});
    check("R8 req", {reqA, reqB}, 2'b11);

    // R9: strobe while pending is ignored
    @(negedge clk);
    cmplValid = 1'b1; cmplFlags = 5'h1F; cmplPc = 32'h5000;
    #5;
    check("R9 no wb pending", {wbA, wbB}, 2'b00);
    @(negedge clk);
    cmplValid = 1'b0; cmplFlags = '0;
    #1;
    check("R9 status unchanged", {rdA, rdB}, {6'b000011, 6'b000011});
    check("R9 pc unchanged", {pcA, pcB}, {32'h4004, 32'h4000});
    check("R9 req held", {reqA, reqB}, 2'b11);
    ack();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule